// File: doc/BRIEF.md
# HDLC receive segment buffer

This block sits behind an HDLC deframer and holds the octets of each received frame until a host collects them. The deframer has already removed flags, stuffing and the checksum. It delivers one octet per `rx_valid` cycle, a start strobe before the first octet and an end strobe after the last octet. The end strobe carries the checksum verdict and an abort indication. Storage is two halves of `SEG_BYTES` octets that are used alternately. A half that has been handed to the host stays locked until the host acknowledges it.

When a half fills and the frame continues, the block raises a segment interrupt. When the frame ends, it raises an end interrupt and reports the length of the final segment, modulo `SEG_BYTES`. The host reads a segment by stepping `host_rd`, then pulses `host_ack` to release the half. If an octet arrives and the half it needs is still locked, the block raises an overflow interrupt and drops the rest of that frame.

Top module: `hdlc_rx_segbuf`

## Requirements
- R1: After `rst`, all three interrupt flags, `irq`, `seg_count`, `end_crc_ok` and `end_aborted` are 0.
- R2: Octets are stored only between a start strobe and the next end strobe. An octet offered outside a frame changes no output and does not appear in the data the host reads.
- R3: When octet number 64k+1 of an open frame arrives (k ≥ 1), `int_seg` is 1 in the following cycle. The host then reads the preceding 64 octets in arrival order.
- R4: The cycle after an end strobe for a frame that holds octets, `int_end` is 1 and `seg_count` equals the final segment length mod 64.
- R5: A frame whose final segment holds exactly 64 octets sets only `int_end` for that segment. `int_seg` stays 0 and `seg_count` reads 0.
- R6: `end_crc_ok` and `end_aborted` take the values of `rx_crc_ok` and `rx_abort` from the end strobe. They hold those values until the next frame end.
- R7: `host_ack` releases the half being read, and the next read starts at offset 0 of the other half. An acknowledge while no segment is pending is ignored.
- R8: An octet whose target half is still unacknowledged sets `int_ovf` in the next cycle and is not stored.
- R9: After an overflow, the remaining octets and the end strobe of that frame are discarded: no `int_end` is raised. The next frame is received normally.
- R10: `host_int_clr` clears all three flags. A flag set in the same cycle is kept. `irq` is the OR of the flags.
- R11: `host_rx_reset` empties the buffer, discards the open frame, clears the flags and the pending segments, and resets the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | An octet is offered on `rx_byte` |
| rx_byte | input | 8 | Received octet |
| rx_sof | input | 1 | Frame start strobe (no octet in that cycle) |
| rx_eof | input | 1 | Frame end strobe (no octet in that cycle) |
| rx_crc_ok | input | 1 | Checksum verdict, valid with `rx_eof` |
| rx_abort | input | 1 | Frame aborted, valid with `rx_eof` |
| host_rd | input | 1 | Advance the read position by one octet |
| host_data | output | 8 | Octet at the current read position |
| host_ack | input | 1 | Release the segment just read |
| host_rx_reset | input | 1 | Receiver reset command |
| host_int_clr | input | 1 | Interrupt register read, clears the flags |
| int_seg | output | 1 | Segment ready flag |
| int_end | output | 1 | Message end flag |
| int_ovf | output | 1 | Overflow flag |
| irq | output | 1 | Any flag set |
| seg_count | output | 6 | Final segment length mod 64 |
| end_crc_ok | output | 1 | Checksum status of the last ended frame |
| end_aborted | output | 1 | Abort status of the last ended frame |

## Verification
If a write half or read half pointer desynchronises, it shows up on `host_data` at offset 0 of the very next segment the host reads, as octets from the wrong half. A wrong fill counter shifts the segment interrupt away from octet 65, or gives a wrong `seg_count`, one cycle after the strobe concerned. A stale pending bit shows up either as a spurious `int_ovf` on the next octet or as a missed overflow when a 129-octet frame arrives with no host service.

// File: rtl/hrx_seg_pkg.sv
package hrx_seg_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_SEG  = 2'd1,
        EV_END  = 2'd2
    } seg_ev_e;

    typedef struct packed {
        logic crc_ok;
        logic aborted;
    } end_stat_t;

    function automatic logic other_half(input logic h);
        return ~h;
    endfunction

endpackage

// File: rtl/hrx_seg_wr.sv
module hrx_seg_wr
    import hrx_seg_pkg::*;
#(
    parameter int SEG_BYTES = 64,
    localparam int IDX_W = $clog2(SEG_BYTES),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             in_crc_ok,
    input  logic             in_abort,
    input  logic [1:0]       pend,
    output logic             we,
    output logic [IDX_W:0]   waddr,
    output logic [7:0]       wdata,
    output seg_ev_e          ev,
    output logic             ev_half,
    output logic [IDX_W-1:0] ev_cnt,
    output end_stat_t        ev_stat,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SEG_BYTES);

    logic             half_q;
    logic             frame_q;
    logic             drop_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full;
    logic             tgt;
    logic             accept;
    logic             closing;

    always_comb begin
        full    = (cnt_q == FULL);
        tgt     = full ? other_half(half_q) : half_q;
        accept  = in_valid && frame_q && !drop_q && !in_sof && !in_eof;
        closing = in_eof && !in_sof && frame_q && !drop_q && (cnt_q != '0);
        we      = 1'b0;
        ovf     = 1'b0;
        ev      = EV_NONE;
        ev_half = half_q;
        ev_cnt  = cnt_q[IDX_W-1:0];
        ev_stat = '{crc_ok: in_crc_ok, aborted: in_abort};
        waddr   = {tgt, full ? {IDX_W{1'b0}} : cnt_q[IDX_W-1:0]};
        wdata   = in_byte;
        if (accept) begin
            if (full) ev = EV_SEG;
            if (pend[tgt]) ovf = 1'b1;
            else           we  = 1'b1;
        end else if (closing) begin
            ev = EV_END;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            half_q  <= 1'b0;
            frame_q <= 1'b0;
            drop_q  <= 1'b0;
            cnt_q   <= '0;
        end else if (in_sof) begin
            frame_q <= 1'b1;
            drop_q  <= 1'b0;
            cnt_q   <= '0;
        end else if (in_eof) begin
            frame_q <= 1'b0;
            drop_q  <= 1'b0;
            cnt_q   <= '0;
            if (closing) half_q <= other_half(half_q);
        end else if (accept) begin
            if (full) half_q <= other_half(half_q);
            if (ovf) begin
                drop_q <= 1'b1;
                cnt_q  <= '0;
            end else begin
                cnt_q <= full ? CNT_W'(1) : cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/hrx_seg_rd.sv
module hrx_seg_rd
    import hrx_seg_pkg::*;
#(
    parameter int SEG_BYTES = 64,
    localparam int IDX_W = $clog2(SEG_BYTES),
    localparam int HALVES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  seg_ev_e           ev,
    input  logic              ev_half,
    input  logic              rd_en,
    input  logic              ack,
    output logic [HALVES-1:0] pend,
    output logic [IDX_W:0]    raddr
);
    logic             rd_half_q;
    logic [IDX_W-1:0] rd_idx_q;
    logic             release_now;

    assign release_now = ack && pend[rd_half_q];

    for (genvar h = 0; h < HALVES; h++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst || flush)
                pend[h] <= 1'b0;
            else if (ev != EV_NONE && ev_half == 1'(h))
                pend[h] <= 1'b1;
            else if (release_now && rd_half_q == 1'(h))
                pend[h] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_half_q <= 1'b0;
            rd_idx_q  <= '0;
        end else if (release_now) begin
            rd_half_q <= other_half(rd_half_q);
            rd_idx_q  <= '0;
        end else if (rd_en) begin
            rd_idx_q <= rd_idx_q + 1'b1;
        end
    end

    assign raddr = {rd_half_q, rd_idx_q};

endmodule

// File: rtl/hrx_seg_mem.sv
module hrx_seg_mem #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/hdlc_rx_segbuf.sv
module hdlc_rx_segbuf
    import hrx_seg_pkg::*;
#(
    parameter int SEG_BYTES = 64,
    localparam int IDX_W = $clog2(SEG_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_crc_ok,
    input  logic             rx_abort,
    input  logic             host_rd,
    output logic [7:0]       host_data,
    input  logic             host_ack,
    input  logic             host_rx_reset,
    input  logic             host_int_clr,
    output logic             int_seg,
    output logic             int_end,
    output logic             int_ovf,
    output logic             irq,
    output logic [IDX_W-1:0] seg_count,
    output logic             end_crc_ok,
    output logic             end_aborted
);
    seg_ev_e          ev;
    logic             ev_half;
    logic [IDX_W-1:0] ev_cnt;
    end_stat_t        ev_stat;
    logic             ovf;
    logic             we;
    logic [IDX_W:0]   waddr;
    logic [IDX_W:0]   raddr;
    logic [7:0]       wdata;
    logic [1:0]       pend;
    end_stat_t        stat_q;

    hrx_seg_wr #(.SEG_BYTES(SEG_BYTES)) wr_i (
        .clk(clk), .rst(rst), .flush(host_rx_reset),
        .in_valid(rx_valid), .in_byte(rx_byte), .in_sof(rx_sof), .in_eof(rx_eof),
        .in_crc_ok(rx_crc_ok), .in_abort(rx_abort), .pend(pend),
        .we(we), .waddr(waddr), .wdata(wdata), .ev(ev), .ev_half(ev_half),
        .ev_cnt(ev_cnt), .ev_stat(ev_stat), .ovf(ovf)
    );

    hrx_seg_rd #(.SEG_BYTES(SEG_BYTES)) rd_i (
        .clk(clk), .rst(rst), .flush(host_rx_reset),
        .ev(ev), .ev_half(ev_half), .rd_en(host_rd), .ack(host_ack),
        .pend(pend), .raddr(raddr)
    );

    hrx_seg_mem #(.DEPTH(2 * SEG_BYTES)) mem_i (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(host_data)
    );

    always_ff @(posedge clk) begin
        if (rst || host_rx_reset) begin
            int_seg   <= 1'b0;
            int_end   <= 1'b0;
            int_ovf   <= 1'b0;
            seg_count <= '0;
            stat_q    <= '0;
        end else begin
            int_seg <= (int_seg && !host_int_clr) || (ev == EV_SEG);
            int_end <= (int_end && !host_int_clr) || (ev == EV_END);
            int_ovf <= (int_ovf && !host_int_clr) || ovf;
            if (ev == EV_END) begin
                seg_count <= ev_cnt;
                stat_q    <= ev_stat;
            end
        end
    end

    assign irq         = int_seg | int_end | int_ovf;
    assign end_crc_ok  = stat_q.crc_ok;
    assign end_aborted = stat_q.aborted;

endmodule

// File: rtl/hdlc_rx_segbuf_chk.sv
module hdlc_rx_segbuf_chk #(
    parameter int SEG_BYTES = 64,
    localparam int IDX_W = $clog2(SEG_BYTES)
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             rx_eof,
    input logic             host_rx_reset,
    input logic             host_int_clr,
    input logic             int_seg,
    input logic             int_end,
    input logic             int_ovf,
    input logic             irq,
    input logic [IDX_W-1:0] seg_count
);
    AST_SEG_NEEDS_OCTET: assert property (@(posedge clk) disable iff (rst)
        $rose(int_seg) |-> $past(rx_valid)); // R3

    AST_END_NEEDS_EOF: assert property (@(posedge clk) disable iff (rst)
        $rose(int_end) |-> $past(rx_eof)); // R4

    AST_COUNT_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(seg_count) |-> ($past(rx_eof) || $past(host_rx_reset))); // R4

    AST_OVF_NEEDS_OCTET: assert property (@(posedge clk) disable iff (rst)
        $rose(int_ovf) |-> $past(rx_valid)); // R8

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (host_int_clr && !rx_valid && !rx_eof) |=> !irq); // R10

    AST_RESET_CMD: assert property (@(posedge clk) disable iff (rst)
        host_rx_reset |=> (!irq && seg_count == '0)); // R11

endmodule

bind hdlc_rx_segbuf hdlc_rx_segbuf_chk #(.SEG_BYTES(SEG_BYTES)) chk_i (.*);

// File: tb/hdlc_rx_segbuf_tb_top.sv
module hdlc_rx_segbuf_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc_ok = 0, rx_abort = 0;
    logic [7:0] rx_byte = 0;
    logic       host_rd = 0, host_ack = 0, host_rx_reset = 0, host_int_clr = 0;
    logic [7:0] host_data;
    logic       int_seg, int_end, int_ovf, irq, end_crc_ok, end_aborted;
    logic [5:0] seg_count;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;
    logic [7:0] fr [0:299];

    always #2 clk = ~clk;

    hdlc_rx_segbuf dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int last_len(input int len);
        return len - 64 * ((len - 1) / 64);
    endfunction

    task automatic pulse_sof();
        rx_sof = 1; @(negedge clk); rx_sof = 0;
    endtask
    task automatic pulse_eof(input bit crc, input bit ab);
        rx_eof = 1; rx_crc_ok = crc; rx_abort = ab; @(negedge clk);
        rx_eof = 0; rx_crc_ok = 0; rx_abort = 0;
    endtask
    task automatic send(input logic [7:0] b);
        rx_valid = 1; rx_byte = b; @(negedge clk); rx_valid = 0;
    endtask
    task automatic clr();
        host_int_clr = 1; @(negedge clk); host_int_clr = 0;
    endtask
    task automatic ack();
        host_ack = 1; @(negedge clk); host_ack = 0;
    endtask
    task automatic read_seg(input int n, input int base, input string req);
        for (int i = 0; i < n; i++) begin
            chk(host_data == fr[base + i], req, host_data, fr[base + i]);
            host_rd = 1; @(negedge clk); host_rd = 0;
        end
    endtask

    task automatic run_frame(input int len, input bit crc, input bit ab);
        int l;
        for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
        pulse_sof();
        for (int k = 1; k <= len; k++) begin
            send(fr[k - 1]);
            if (k > 64 && (k - 1) % 64 == 0) begin
                chk(int_seg == 1, "R3 seg flag", int_seg, 1);
                chk(int_ovf == 0, "R8 no overflow when serviced", int_ovf, 0);
                clr();
                read_seg(64, k - 65, "R3 segment data");
                ack();
            end
        end
        pulse_eof(crc, ab);
        l = last_len(len);
        chk(int_end == 1, "R4 end flag", int_end, 1);
        chk(seg_count == 6'(l % 64), "R4 count", seg_count, l % 64);
        if (l == 64) chk(int_seg == 0, "R5 no seg flag on full last", int_seg, 0);
        chk(end_crc_ok == crc, "R6 crc status", end_crc_ok, crc);
        chk(end_aborted == ab, "R6 abort status", end_aborted, ab);
        clr();
        chk(irq == 0, "R10 clear on read", irq, 0);
        read_seg(l, len - l, "R7 last segment data");
        ack();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(irq == 0 && int_seg == 0 && int_end == 0 && int_ovf == 0, "R1 flags", irq, 0);
        chk(seg_count == 0 && end_crc_ok == 0 && end_aborted == 0, "R1 status", seg_count, 0);

        // R7 stray acknowledge with nothing pending
        ack();
        // R2 octets outside a frame
        for (int i = 0; i < 5; i++) send(8'hA5);
        chk(irq == 0, "R2 outside octets ignored", irq, 0);
        run_frame(10, 1, 0);

        // R5 exact boundaries
        run_frame(64, 1, 0);
        run_frame(65, 0, 1);
        run_frame(128, 1, 0);
        run_frame(1, 0, 0);

        // R8 / R9 overflow: 129 octets without service
        for (int i = 0; i < 140; i++) fr[i] = 8'($urandom);
        pulse_sof();
        for (int k = 0; k < 128; k++) send(fr[k]);
        chk(int_ovf == 0, "R8 no overflow at 128", int_ovf, 0);
        send(fr[128]);
        chk(int_ovf == 1, "R8 overflow flag", int_ovf, 1);
        chk(int_seg == 1, "R3 seg flag before overflow", int_seg, 1);
        for (int k = 129; k < 135; k++) send(fr[k]);
        pulse_eof(1, 0);
        chk(int_end == 0, "R9 end of dropped frame ignored", int_end, 0);
        clr();
        read_seg(64, 0, "R9 first kept segment");
        ack();
        read_seg(64, 64, "R9 second kept segment");
        ack();
        run_frame(10, 1, 1);

        // R11 receiver reset mid-frame with a pending segment
        pulse_sof();
        for (int k = 0; k < 70; k++) send(8'($urandom));
        chk(int_seg == 1, "R3 seg before reset", int_seg, 1);
        host_rx_reset = 1; @(negedge clk); host_rx_reset = 0;
        chk(irq == 0, "R11 flags cleared", irq, 0);
        pulse_eof(1, 0);
        chk(int_end == 0, "R11 open frame discarded", int_end, 0);
        run_frame(5, 0, 0);

        // random frames with garbage between them
        for (int f = 0; f < 25; f++) begin
            for (int g = 0; g < int'($urandom_range(0, 3)); g++) send(8'($urandom));
            run_frame(int'($urandom_range(1, 200)), 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule